// File: doc/BRIEF.md
# Carrier PWM Generator with Sample Trigger

This block produces one pulse-width-modulated output for a digital power-converter control loop. A position counter sweeps a carrier of programmable length, and the output is formed by comparing the carrier against an active compare value. Three carrier shapes are available: a rising ramp, a falling ramp and a symmetric up/down triangle. A fourth setting bypasses the carrier, so that the output follows the most recently written duty value directly. The same position counter also fires an analog sampling strobe at a programmable phase, once or twice per carrier.

The control processor writes each new duty value into a holding register with a one-cycle strobe. The active compare value is refreshed from that holding register only at update instants. These are the carrier bottom, and in double-rate mode the triangle top as well. The instant at which a write lands relative to those update points therefore decides whether the loop sees it one update sooner or later. Period, shape, update rate, sampling rate and phase are all sampled at the carrier bottom, so a carrier already in progress always runs to its end with the settings it started with.

Top module: `cpwm_gen`

## Requirements
- R1: While reset is asserted, pwm_out, sample_trig, evt_bottom and evt_top are all low. After reset is released, the first bottom event is shown in the third clock cycle.
- R2: Rising-ramp carrier (shape code 0). The carrier position counts 0 to P-1, where P is the period. pwm_out is high while the position is below the compare value D, which gives min(D,P) high cycles that start at position 0.
- R3: Falling-ramp carrier (shape code 1). The position counts 0 to P-1, and pwm_out is high once the position reaches P-D. The min(D,P) high cycles therefore sit at the end of the carrier.
- R4: Triangle carrier (shape code 2). The carrier lasts 2P cycles, and the count runs 0,1,…,P,P-1,…,1. pwm_out is high while the count is below D, which gives 2D-1 high cycles when 0<D<P. evt_top pulses for one cycle when the count equals P, and never in the same cycle as evt_bottom.
- R5: In single-rate update, the compare value is reloaded only for the bottom cycle (position 0). A write strobed in any cycle before the bottom cycle takes effect from that bottom. A write strobed in the bottom cycle or later waits one full carrier.
- R6: In triangle mode with double-rate update set, the compare value is also reloaded for the top cycle, under the same write-timing rule. Each half of the carrier can then use a different duty.
- R7: A duty of 0 holds pwm_out low for the whole carrier. A duty of P or more holds it high for the whole carrier. This applies to every carrier shape, with no pulse at the turnaround.
- R8: sample_trig pulses when the position equals the phase setting. When double-rate sampling is set, it also pulses at the phase plus half the carrier length, which gives two strobes per carrier.
- R9: Changes to period, shape, update rate, sampling rate or phase take effect from the next bottom event. The carrier in progress keeps its length.
- R10: With shape code 3 (direct), pwm_out is high from the cycle after a write of nonzero data and low from the cycle after a write of zero, without waiting for any update event. The position counter keeps running as a ramp of length P.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | CW | Carrier period P in clock cycles (P ≥ 2) |
| cfg_shape | input | 2 | 0 rising ramp, 1 falling ramp, 2 triangle, 3 direct |
| cfg_dbl_upd | input | 1 | Double-rate duty update (triangle only) |
| cfg_dbl_smp | input | 1 | Two sample strobes per carrier |
| cfg_phase | input | CW | Sample strobe position within the carrier |
| duty_wr | input | 1 | Duty write strobe |
| duty_data | input | CW | Duty value to write |
| pwm_out | output | 1 | Modulated output |
| sample_trig | output | 1 | Sampling strobe |
| evt_bottom | output | 1 | Carrier bottom (start of carrier) pulse |
| evt_top | output | 1 | Triangle top pulse |

## Verification
The case that needs the most care is a duty write that arrives in the same cycle as an update event. A strobe placed in the cycle just before the bottom or top must be picked up by that reload. A strobe placed in the bottom or top cycle itself must be held back until the next reload. The bench provokes this by issuing writes at exact offsets inside a carrier, counted from an observed bottom pulse, namely the last cycle before the reload and the reload cycle itself. It then judges the outcome from the number of high cycles in the current carrier and in the following one. Configuration changes made in the bottom cycle are checked the same way, by measuring the length of the carrier in progress and of the next one.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;
  typedef enum logic [1:0] {
    SH_RISE   = 2'd0,
    SH_FALL   = 2'd1,
    SH_TRI    = 2'd2,
    SH_DIRECT = 2'd3
  } shape_e;
endpackage

// File: rtl/cpwm_timebase.sv
`timescale 1ns/1ps
module cpwm_timebase
  import cpwm_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_period,
  input  logic [1:0]    cfg_shape,
  input  logic          cfg_dbl_upd,
  input  logic          cfg_dbl_smp,
  input  logic [CW-1:0] cfg_phase,
  output logic          armed,
  output logic [CW:0]   pos,
  output logic [CW-1:0] per_a,
  output shape_e        shape_a,
  output logic          upd_next,
  output logic          evt_bottom,
  output logic          evt_top,
  output logic          sample_trig
);
  localparam int PW = CW + 1;
  localparam logic [PW-1:0] ONE = PW'(1);

  // state
  logic          armed_q;
  logic [PW-1:0] pos_q;
  logic [CW-1:0] per_q;
  shape_e        shape_q;
  logic          dupd_q;
  logic          dsmp_q;
  logic [CW-1:0] ph_q;

  // next-state
  logic          is_tri;
  logic [PW-1:0] per_x;
  logic [PW-1:0] ph_x;
  logic [PW-1:0] len;
  logic [PW-1:0] half;
  logic          wrap_nxt;
  logic [PW-1:0] pos_nxt;
  logic          upd_nxt;

  always_comb begin
    is_tri   = (shape_q == SH_TRI);
    per_x    = {1'b0, per_q};
    ph_x     = {1'b0, ph_q};
    len      = is_tri ? {per_q, 1'b0} : per_x;
    half     = len >> 1;
    wrap_nxt = !armed_q || (pos_q == len - ONE);
    pos_nxt  = wrap_nxt ? '0 : pos_q + ONE;
    upd_nxt  = wrap_nxt || (is_tri && dupd_q && (pos_nxt == per_x));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pos_q   <= '0;
      per_q   <= '0;
      shape_q <= SH_RISE;
      dupd_q  <= 1'b0;
      dsmp_q  <= 1'b0;
      ph_q    <= '0;
    end else begin
      armed_q <= 1'b1;
      pos_q   <= pos_nxt;
      if (wrap_nxt) begin
        per_q   <= cfg_period;
        shape_q <= shape_e'(cfg_shape);
        dupd_q  <= cfg_dbl_upd;
        dsmp_q  <= cfg_dbl_smp;
        ph_q    <= cfg_phase;
      end
    end
  end

  assign armed       = armed_q;
  assign pos         = pos_q;
  assign per_a       = per_q;
  assign shape_a     = shape_q;
  assign upd_next    = upd_nxt;
  assign evt_bottom  = armed_q && (pos_q == '0);
  assign evt_top     = armed_q && is_tri && (pos_q == per_x);
  assign sample_trig = armed_q &&
                       ((pos_q == ph_x) || (dsmp_q && (pos_q == ph_x + half)));

  // R2/R3/R4: position stays inside the active carrier
  a_r2_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (pos_q < len));

  // R9: period held for the whole carrier, changes only into a bottom cycle
  a_r9_period_held: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && pos_q != '0) |-> $stable(per_q));

  // R4: top and bottom never coincide
  a_r4_top_not_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_top && evt_bottom));

  // R8: single-rate sampling never strobes twice in a row within a carrier
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!dsmp_q && sample_trig) |=> (!sample_trig || evt_bottom));
endmodule

// File: rtl/cpwm_duty.sv
`timescale 1ns/1ps
module cpwm_duty #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          duty_wr,
  input  logic [CW-1:0] duty_data,
  input  logic          upd_next,
  output logic [CW-1:0] cmp,
  output logic          dir
);
  logic [CW-1:0] sh_q, sh_nxt;
  logic [CW-1:0] cmp_q, cmp_nxt;
  logic          dir_q, dir_nxt;

  // a write in the cycle before an update is forwarded into the reload
  always_comb begin
    sh_nxt  = duty_wr ? duty_data : sh_q;
    cmp_nxt = upd_next ? sh_nxt : cmp_q;
    dir_nxt = duty_wr ? (|duty_data) : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cmp_q <= '0;
      dir_q <= 1'b0;
    end else begin
      sh_q  <= sh_nxt;
      cmp_q <= cmp_nxt;
      dir_q <= dir_nxt;
    end
  end

  assign cmp = cmp_q;
  assign dir = dir_q;

  // R5: compare value changes only after an update point
  a_r5_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(upd_next) |-> $stable(cmp_q));
endmodule

// File: rtl/cpwm_compare.sv
`timescale 1ns/1ps
module cpwm_compare
  import cpwm_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          armed,
  input  logic [CW:0]   pos,
  input  logic [CW-1:0] per_a,
  input  shape_e        shape_a,
  input  logic [CW-1:0] cmp,
  input  logic          dir,
  output logic          pwm
);
  localparam int PW = CW + 1;

  logic [PW-1:0] per_x, cmp_x, cnt;
  logic          full, hit;

  always_comb begin
    per_x = {1'b0, per_a};
    cmp_x = {1'b0, cmp};
    cnt   = (pos <= per_x) ? pos : ({per_a, 1'b0} - pos);
    full  = (cmp_x >= per_x);
    case (shape_a)
      SH_RISE:  hit = full || (pos < cmp_x);
      SH_FALL:  hit = full || ((pos + cmp_x) >= per_x);
      SH_TRI:   hit = full || (cnt < cmp_x);
      default:  hit = dir;
    endcase
    pwm = armed && hit;
  end
endmodule

// File: rtl/cpwm_gen.sv
`timescale 1ns/1ps
module cpwm_gen
  import cpwm_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_period,
  input  logic [1:0]    cfg_shape,
  input  logic          cfg_dbl_upd,
  input  logic          cfg_dbl_smp,
  input  logic [CW-1:0] cfg_phase,
  input  logic          duty_wr,
  input  logic [CW-1:0] duty_data,
  output logic          pwm_out,
  output logic          sample_trig,
  output logic          evt_bottom,
  output logic          evt_top
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic          armed;
  logic [CW:0]   pos;
  logic [CW-1:0] per_a;
  shape_e        shape_a;
  logic          upd_next;
  logic [CW-1:0] cmp;
  logic          dir;

  cpwm_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_i),
    .cfg_period(cfg_period), .cfg_shape(cfg_shape),
    .cfg_dbl_upd(cfg_dbl_upd), .cfg_dbl_smp(cfg_dbl_smp), .cfg_phase(cfg_phase),
    .armed(armed), .pos(pos), .per_a(per_a), .shape_a(shape_a),
    .upd_next(upd_next), .evt_bottom(evt_bottom), .evt_top(evt_top),
    .sample_trig(sample_trig)
  );

  cpwm_duty #(.CW(CW)) u_duty (
    .clk(clk), .rst_n(rst_i),
    .duty_wr(duty_wr), .duty_data(duty_data), .upd_next(upd_next),
    .cmp(cmp), .dir(dir)
  );

  cpwm_compare #(.CW(CW)) u_cmp (
    .armed(armed), .pos(pos), .per_a(per_a), .shape_a(shape_a),
    .cmp(cmp), .dir(dir), .pwm(pwm_out)
  );

  // R7: zero duty never raises the carrier output
  a_r7_zero_low: assert property (@(posedge clk) disable iff (!rst_i)
    (armed && shape_a != SH_DIRECT && cmp == '0) |-> !pwm_out);

  // R10: direct mode shows the previous cycle's write at once
  a_r10_direct_follow: assert property (@(posedge clk) disable iff (!rst_i)
    (armed && $past(armed) && shape_a == SH_DIRECT && $past(shape_a) == SH_DIRECT
     && $past(duty_wr)) |-> (pwm_out == (|$past(duty_data))));
endmodule

// File: tb/cpwm_gen_test.sv
`timescale 1ns/1ps
module cpwm_gen_test;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cfg_period;
  logic [1:0]    cfg_shape;
  logic          cfg_dbl_upd;
  logic          cfg_dbl_smp;
  logic [CW-1:0] cfg_phase;
  logic          duty_wr;
  logic [CW-1:0] duty_data;
  logic          pwm_out, sample_trig, evt_bottom, evt_top;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cpwm_gen #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_period(cfg_period), .cfg_shape(cfg_shape),
    .cfg_dbl_upd(cfg_dbl_upd), .cfg_dbl_smp(cfg_dbl_smp), .cfg_phase(cfg_phase),
    .duty_wr(duty_wr), .duty_data(duty_data),
    .pwm_out(pwm_out), .sample_trig(sample_trig),
    .evt_bottom(evt_bottom), .evt_top(evt_top)
  );

  // shape, period, duty, expected high cycles, expected length, first high index
  localparam int NV = 10;
  localparam int VT [NV][6] = '{
    '{0, 10,  3,  3, 10,  0},
    '{0, 10,  0,  0, 10, -1},
    '{0, 10, 12, 10, 10,  0},
    '{1,  8,  5,  5,  8,  3},
    '{1,  8,  8,  8,  8,  0},
    '{2,  6,  4,  7, 12,  0},
    '{2,  6,  6, 12, 12,  0},
    '{2,  6,  0,  0, 12, -1},
    '{3,  7,  5,  7,  7,  0},
    '{0,  5,  1,  1,  5,  0}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // call in a bottom cycle; runs one carrier, optionally writing at index wi
  task automatic measure(input int wi, input int wv,
                         output int hi, output int len, output int first,
                         output int top, output int tr0, output int tr1,
                         output int ntr);
    hi = 0; len = 0; first = -1; top = -1; tr0 = -1; tr1 = -1; ntr = 0;
    do begin
      if (len == wi) begin
        duty_wr   = 1'b1;
        duty_data = CW'(wv);
      end
      if (pwm_out) begin
        if (first < 0) first = len;
        hi++;
      end
      if (evt_top && top < 0) top = len;
      if (sample_trig) begin
        if (ntr == 0) tr0 = len;
        else          tr1 = len;
        ntr++;
      end
      step();
      duty_wr = 1'b0;
      len++;
    end while (!evt_bottom && len < 5000);
  endtask

  function automatic string vtag(input int sh, input int per, input int d);
    if (d == 0 || d >= per) return "R7";
    case (sh)
      0:       return "R2";
      1:       return "R3";
      2:       return "R4";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int hi, len, first, top, tr0, tr1, ntr;
    rst_n = 1'b0;
    cfg_period = 12'd10; cfg_shape = 2'd0;
    cfg_dbl_upd = 1'b0; cfg_dbl_smp = 1'b0; cfg_phase = '0;
    duty_wr = 1'b0; duty_data = '0;

    // R1: reset state and first bottom
    repeat (3) step();
    chk("R1", "outputs in reset",
        int'({pwm_out, sample_trig, evt_bottom, evt_top}), 0);
    rst_n = 1'b1;
    step();
    step();
    chk("R1", "no bottom before release completes", int'(evt_bottom), 0);
    step();
    chk("R1", "first bottom third cycle", int'(evt_bottom), 1);

    // vector table
    for (int v = 0; v < NV; v++) begin
      cfg_shape  = 2'(VT[v][0]);
      cfg_period = CW'(VT[v][1]);
      measure(0, VT[v][2], hi, len, first, top, tr0, tr1, ntr);
      measure(-1, 0, hi, len, first, top, tr0, tr1, ntr);
      chk(vtag(VT[v][0], VT[v][1], VT[v][2]), "high cycles", hi, VT[v][3]);
      chk(vtag(VT[v][0], VT[v][1], VT[v][2]), "carrier length", len, VT[v][4]);
      chk(vtag(VT[v][0], VT[v][1], VT[v][2]), "first high index", first, VT[v][5]);
    end

    // R5: write timing against the bottom reload
    cfg_shape = 2'd0; cfg_period = 12'd10;
    measure(0, 2, hi, len, first, top, tr0, tr1, ntr);
    measure(-1, 0, hi, len, first, top, tr0, tr1, ntr);
    chk("R5", "settled duty", hi, 2);
    measure(9, 7, hi, len, first, top, tr0, tr1, ntr);
    chk("R5", "late write not in current", hi, 2);
    measure(0, 4, hi, len, first, top, tr0, tr1, ntr);
    chk("R5", "write before bottom applied", hi, 7);
    measure(-1, 0, hi, len, first, top, tr0, tr1, ntr);
    chk("R5", "write in bottom cycle waited", hi, 4);

    // R6: double-rate reload at the triangle top
    cfg_shape = 2'd2; cfg_period = 12'd6; cfg_dbl_upd = 1'b1;
    measure(0, 2, hi, len, first, top, tr0, tr1, ntr);
    measure(-1, 0, hi, len, first, top, tr0, tr1, ntr);
    chk("R4", "top index", top, 6);
    chk("R6", "equal halves", hi, 3);
    measure(5, 5, hi, len, first, top, tr0, tr1, ntr);
    chk("R6", "write before top applied", hi, 6);
    measure(6, 1, hi, len, first, top, tr0, tr1, ntr);
    chk("R6", "write in top cycle waited", hi, 9);
    measure(-1, 0, hi, len, first, top, tr0, tr1, ntr);
    chk("R6", "applied at next bottom", hi, 1);

    // R8: sample strobe placement
    cfg_dbl_upd = 1'b0;
    cfg_shape = 2'd0; cfg_period = 12'd10; cfg_phase = 12'd5;
    measure(-1, 0, hi, len, first, top, tr0, tr1, ntr);
    measure(-1, 0, hi, len, first, top, tr0, tr1, ntr);
    chk("R8", "single strobe count", ntr, 1);
    chk("R8", "single strobe index", tr0, 5);
    cfg_shape = 2'd2; cfg_period = 12'd6; cfg_phase = 12'd2; cfg_dbl_smp = 1'b1;
    measure(-1, 0, hi, len, first, top, tr0, tr1, ntr);
    measure(-1, 0, hi, len, first, top, tr0, tr1, ntr);
    chk("R8", "double strobe count", ntr, 2);
    chk("R8", "first strobe index", tr0, 2);
    chk("R8", "second strobe index", tr1, 8);

    // R9: settings wait for the next bottom
    cfg_shape = 2'd0; cfg_period = 12'd10; cfg_phase = '0; cfg_dbl_smp = 1'b0;
    measure(-1, 0, hi, len, first, top, tr0, tr1, ntr);
    measure(-1, 0, hi, len, first, top, tr0, tr1, ntr);
    chk("R9", "baseline length", len, 10);
    cfg_period = 12'd4;
    measure(-1, 0, hi, len, first, top, tr0, tr1, ntr);
    chk("R9", "period change not truncating", len, 10);
    measure(-1, 0, hi, len, first, top, tr0, tr1, ntr);
    chk("R9", "new period applied", len, 4);
    cfg_shape = 2'd2;
    measure(-1, 0, hi, len, first, top, tr0, tr1, ntr);
    chk("R9", "shape change deferred", len, 4);
    measure(-1, 0, hi, len, first, top, tr0, tr1, ntr);
    chk("R9", "triangle after change", len, 8);

    // R10: direct output follows writes immediately
    cfg_shape = 2'd3; cfg_period = 12'd8;
    measure(0, 0, hi, len, first, top, tr0, tr1, ntr);
    measure(2, 9, hi, len, first, top, tr0, tr1, ntr);
    chk("R10", "high after nonzero write", hi, 5);
    chk("R10", "rise index", first, 3);
    chk("R10", "ramp length kept", len, 8);
    measure(4, 0, hi, len, first, top, tr0, tr1, ntr);
    chk("R10", "low after zero write", hi, 5);
    chk("R10", "high from start", first, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule